// File: doc/BRIEF.md
# Status-Driven Bus Command Controller

This block sits next to a processor core whose bus activity is announced only by a three-bit status code. It watches that code on every clock and turns it into separate, registered command strobes: memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also drives an address-latch strobe, a data-buffer enable and a data-direction line for the external latches and transceivers. A code fetch is presented to memory as an ordinary memory read.

A bus cycle opens when the status leaves the all-ones passive code. The block latches the command type at that point and pulses the address latch for one clock. It then raises the command in the following clock and holds it until it sees the passive code again with ready high. Write cycles also get an early write strobe that rises one clock before the normal write strobe. The halt code runs through the same cycle framing but raises no command and no data enable.

Two side decoders turn the two-bit segment-in-use code and the two-bit instruction-queue status code into registered one-hot indicators.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: While `rst` is high and in the first clock after it, every command strobe, `ale` and `den` are low, `dir_tx` is high, and both one-hot outputs read 4'b0001.
- R2: The command type is taken from the status code: 0 gives `int_ack`, 1 gives `io_rd`, 2 gives `io_wr`/`io_wr_early`, 3 (halt) gives no strobe, 4 (code fetch) and 5 give `mem_rd`, 6 gives `mem_wr`/`mem_wr_early`, and 7 is passive. At most one of `mem_rd`, `mem_wr`, `io_rd`, `io_wr`, `int_ack` is high at any time.
- R3: A cycle starts at a clock edge where the sampled status is not 7 and the status sampled at the previous edge was 7, with no cycle in progress. `ale` is high for exactly the one clock that follows that edge.
- R4: `mem_rd`, `io_rd` and `int_ack` rise one clock after `ale` and stay high until the first edge that samples status 7 with `rdy` high. They fall after that edge.
- R5: While the status is passive but `rdy` is low, an active command stays asserted.
- R6: `mem_wr_early`/`io_wr_early` rise together with the read strobes (one clock after `ale`). `mem_wr`/`io_wr` rise one clock later. Both fall after the same ending edge as in R4.
- R7: `dir_tx` is low (receive) from the `ale` clock until the cycle ends for codes 0, 1, 4 and 5, and high for every other code and when no cycle is in progress.
- R8: `den` is high from the clock after `ale` until the cycle ends, for every code except halt.
- R9: A halt cycle (code 3) pulses `ale` but raises no command strobe and no `den`.
- R10: A change of status from one non-passive code to another while a cycle is in progress starts no new cycle and leaves the active strobes unchanged. A new cycle needs the status to be sampled at 7 first.
- R11: `seg_hot` is a one-hot code whose set bit index equals `seg_code` sampled at the previous clock edge (0 extra, 1 stack, 2 code, 3 data).
- R12: `qs_hot` is a one-hot code whose set bit index equals `qs_code` sampled at the previous edge (0 no operation, 1 first opcode byte, 2 queue emptied, 3 following byte).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stat | input | 3 | Processor bus status code |
| rdy | input | 1 | Ready; low extends the end of a cycle |
| seg_code | input | 2 | Segment-in-use code |
| qs_code | input | 2 | Instruction-queue status code |
| mem_rd | output | 1 | Memory read command (data read and code fetch) |
| mem_wr | output | 1 | Memory write command |
| mem_wr_early | output | 1 | Early memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| io_wr_early | output | 1 | Early I/O write command |
| int_ack | output | 1 | Interrupt acknowledge command |
| ale | output | 1 | Address latch strobe |
| den | output | 1 | Data buffer enable |
| dir_tx | output | 1 | Data direction: 1 drive out, 0 receive |
| seg_hot | output | 4 | One-hot segment-in-use indicator |
| qs_hot | output | 4 | One-hot queue status indicator |

## Verification
The address-latch property assumes the status input sits at the passive code 7 during reset, so the history it looks back on matches the reset value of the internal status register. The stimulus drives 7 through reset and changes inputs only on falling edges. The strobe-hold properties assume a cycle ends only through a sampled passive code with ready high, so the stimulus never asserts reset in the middle of a cycle. Every cycle in the stimulus is held for at least one full command clock before it returns to passive. This lets the normal write strobe appear before the cycle ends.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int STAT_W = 3;

  typedef enum logic [STAT_W-1:0] {
    ST_INTA    = 3'd0,
    ST_IO_RD   = 3'd1,
    ST_IO_WR   = 3'd2,
    ST_HALT    = 3'd3,
    ST_FETCH   = 3'd4,
    ST_MEM_RD  = 3'd5,
    ST_MEM_WR  = 3'd6,
    ST_PASSIVE = 3'd7
  } bus_stat_e;

  typedef struct packed {
    logic mrd;
    logic mwr;
    logic iord;
    logic iowr;
    logic inta;
    logic halt;
    logic rx_dir;
  } cmd_flags_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PH1  = 2'd1,
    SQ_ACT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bcc_stat_decode.sv
module bcc_stat_decode
  import bcc_pkg::*;
(
  input  logic [STAT_W-1:0] stat,
  output cmd_flags_t        flags
);
  always_comb begin
    flags = '0;
    case (stat)
      ST_INTA:   begin flags.inta = 1'b1; flags.rx_dir = 1'b1; end
      ST_IO_RD:  begin flags.iord = 1'b1; flags.rx_dir = 1'b1; end
      ST_IO_WR:  flags.iowr = 1'b1;
      ST_HALT:   flags.halt = 1'b1;
      ST_FETCH:  begin flags.mrd = 1'b1; flags.rx_dir = 1'b1; end
      ST_MEM_RD: begin flags.mrd = 1'b1; flags.rx_dir = 1'b1; end
      ST_MEM_WR: flags.mwr = 1'b1;
      default:   flags = '0;
    endcase
  end
endmodule

// File: rtl/bcc_onehot_reg.sv
module bcc_onehot_reg #(
  parameter int CODE_W = 2,
  localparam int N = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic [N-1:0]      hot
);
  logic [N-1:0] hot_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign hot_d[i] = (code == CODE_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) hot <= N'(1);
    else     hot <= hot_d;
  end
endmodule

// File: rtl/bcc_cycle_fsm.sv
module bcc_cycle_fsm
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat,
  input  logic              rdy,
  output logic              start,
  output logic              in_ph1,
  output logic              in_act,
  output logic              finish
);
  localparam logic [STAT_W-1:0] PASSIVE = ST_PASSIVE;

  seq_state_e        state, state_d;
  logic [STAT_W-1:0] stat_q;

  assign start  = (state == SQ_IDLE) && (stat_q == PASSIVE) && (stat != PASSIVE);
  assign in_ph1 = (state == SQ_PH1);
  assign in_act = (state == SQ_ACT);
  assign finish = in_act && (stat == PASSIVE) && rdy;

  always_comb begin
    state_d = state;
    case (state)
      SQ_IDLE: if (start)  state_d = SQ_PH1;
      SQ_PH1:              state_d = SQ_ACT;
      SQ_ACT:  if (finish) state_d = SQ_IDLE;
      default:             state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      stat_q <= PASSIVE;
    end else begin
      state  <= state_d;
      stat_q <= stat;
    end
  end
endmodule

// File: rtl/bcc_strobe_gen.sv
module bcc_strobe_gen
  import bcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cmd_flags_t flags,
  input  logic       start,
  input  logic       in_ph1,
  input  logic       in_act,
  input  logic       finish,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       mem_wr_early,
  output logic       io_rd,
  output logic       io_wr,
  output logic       io_wr_early,
  output logic       int_ack,
  output logic       ale,
  output logic       den,
  output logic       dir_tx
);
  cmd_flags_t cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q        <= '0;
      mem_rd       <= 1'b0;
      mem_wr       <= 1'b0;
      mem_wr_early <= 1'b0;
      io_rd        <= 1'b0;
      io_wr        <= 1'b0;
      io_wr_early  <= 1'b0;
      int_ack      <= 1'b0;
      ale          <= 1'b0;
      den          <= 1'b0;
      dir_tx       <= 1'b1;
    end else begin
      ale <= start;
      if (start) begin
        cmd_q  <= flags;
        dir_tx <= ~flags.rx_dir;
      end
      if (in_ph1) begin
        mem_rd       <= cmd_q.mrd;
        io_rd        <= cmd_q.iord;
        int_ack      <= cmd_q.inta;
        mem_wr_early <= cmd_q.mwr;
        io_wr_early  <= cmd_q.iowr;
        den          <= ~cmd_q.halt;
      end
      if (in_act && !finish) begin
        mem_wr <= cmd_q.mwr;
        io_wr  <= cmd_q.iowr;
      end
      if (finish) begin
        mem_rd       <= 1'b0;
        mem_wr       <= 1'b0;
        mem_wr_early <= 1'b0;
        io_rd        <= 1'b0;
        io_wr        <= 1'b0;
        io_wr_early  <= 1'b0;
        int_ack      <= 1'b0;
        den          <= 1'b0;
        dir_tx       <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
  import bcc_pkg::*;
#(
  parameter int SEG_W = 2,
  parameter int QS_W  = 2,
  localparam int SEG_N = 1 << SEG_W,
  localparam int QS_N  = 1 << QS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] bus_stat,
  input  logic              rdy,
  input  logic [SEG_W-1:0]  seg_code,
  input  logic [QS_W-1:0]   qs_code,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_wr_early,
  output logic              io_rd,
  output logic              io_wr,
  output logic              io_wr_early,
  output logic              int_ack,
  output logic              ale,
  output logic              den,
  output logic              dir_tx,
  output logic [SEG_N-1:0]  seg_hot,
  output logic [QS_N-1:0]   qs_hot
);
  cmd_flags_t flags;
  logic       start, in_ph1, in_act, finish;

  bcc_stat_decode u_dec (
    .stat  (bus_stat),
    .flags (flags)
  );

  bcc_cycle_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .stat   (bus_stat),
    .rdy    (rdy),
    .start  (start),
    .in_ph1 (in_ph1),
    .in_act (in_act),
    .finish (finish)
  );

  bcc_strobe_gen u_strb (
    .clk          (clk),
    .rst          (rst),
    .flags        (flags),
    .start        (start),
    .in_ph1       (in_ph1),
    .in_act       (in_act),
    .finish       (finish),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .mem_wr_early (mem_wr_early),
    .io_rd        (io_rd),
    .io_wr        (io_wr),
    .io_wr_early  (io_wr_early),
    .int_ack      (int_ack),
    .ale          (ale),
    .den          (den),
    .dir_tx       (dir_tx)
  );

  bcc_onehot_reg #(.CODE_W(SEG_W)) u_seg (
    .clk  (clk),
    .rst  (rst),
    .code (seg_code),
    .hot  (seg_hot)
  );

  bcc_onehot_reg #(.CODE_W(QS_W)) u_qs (
    .clk  (clk),
    .rst  (rst),
    .code (qs_code),
    .hot  (qs_hot)
  );
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] bus_stat,
  input logic       rdy,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       mem_wr_early,
  input logic       io_rd,
  input logic       io_wr,
  input logic       io_wr_early,
  input logic       int_ack,
  input logic       ale,
  input logic       den,
  input logic       dir_tx,
  input logic [3:0] seg_hot,
  input logic [3:0] qs_hot
);
  // R2
  cmd_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({mem_rd, mem_wr, io_rd, io_wr, int_ack}) <= 1);

  // R3
  ale_single_chk: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  // R3
  ale_after_passive_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> ($past(bus_stat) != 3'd7) && ($past(bus_stat, 2) == 3'd7));

  // R4
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_rd) |-> ($past(bus_stat) == 3'd7) && $past(rdy));

  // R5
  hold_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !rdy) |=> io_rd);

  // R6
  mem_early_lead_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr) |-> $past(mem_wr_early));

  // R6
  io_early_cover_chk: assert property (@(posedge clk) disable iff (rst)
    io_wr |-> io_wr_early);

  // R7
  dir_read_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || io_rd || int_ack) |-> !dir_tx);

  // R7
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_early || io_wr_early) |-> dir_tx);

  // R8
  den_with_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr_early || io_rd || io_wr_early || int_ack) |-> den);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ale && $past(bus_stat) == 3'd3) |=> !den);

  // R11
  seg_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(seg_hot) == 1);

  // R12
  qs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(qs_hot) == 1);
endmodule

bind bus_cmd_ctrl bcc_checker u_bcc_checker (
  .clk          (clk),
  .rst          (rst),
  .bus_stat     (bus_stat),
  .rdy          (rdy),
  .mem_rd       (mem_rd),
  .mem_wr       (mem_wr),
  .mem_wr_early (mem_wr_early),
  .io_rd        (io_rd),
  .io_wr        (io_wr),
  .io_wr_early  (io_wr_early),
  .int_ack      (int_ack),
  .ale          (ale),
  .den          (den),
  .dir_tx       (dir_tx),
  .seg_hot      (seg_hot),
  .qs_hot       (qs_hot)
);

// File: tb/bus_cmd_ctrl_bench.sv
module bus_cmd_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_stat = 3'd7;
  logic       rdy = 1'b1;
  logic [1:0] seg_code = 2'd0;
  logic [1:0] qs_code = 2'd0;
  logic       mem_rd, mem_wr, mem_wr_early, io_rd, io_wr, io_wr_early;
  logic       int_ack, ale, den, dir_tx;
  logic [3:0] seg_hot, qs_hot;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cmd_ctrl u_bus_cmd_ctrl (
    .clk(clk), .rst(rst), .bus_stat(bus_stat), .rdy(rdy),
    .seg_code(seg_code), .qs_code(qs_code),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wr_early(mem_wr_early),
    .io_rd(io_rd), .io_wr(io_wr), .io_wr_early(io_wr_early),
    .int_ack(int_ack), .ale(ale), .den(den), .dir_tx(dir_tx),
    .seg_hot(seg_hot), .qs_hot(qs_hot)
  );

  // Packed order: mem_rd mem_wr mem_wr_early io_rd io_wr io_wr_early int_ack ale den dir_tx
  function automatic logic [9:0] outs();
    return {mem_rd, mem_wr, mem_wr_early, io_rd, io_wr, io_wr_early,
            int_ack, ale, den, dir_tx};
  endfunction

  // ph: 0 idle, 1 ale clock, 2 first command clock, 3 full command
  function automatic logic [9:0] expect_vec(input int code, input int ph);
    logic on, full, rx;
    on   = (ph >= 2);
    full = (ph == 3);
    rx   = (code == 0) || (code == 1) || (code == 4) || (code == 5);
    return {on && (code == 4 || code == 5),
            full && code == 6,
            on && code == 6,
            on && code == 1,
            full && code == 2,
            on && code == 2,
            on && code == 0,
            ph == 1,
            on && code != 3,
            !(ph >= 1 && rx)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Full bus cycle; wait_clks > 0 holds rdy low at the passive code
  task automatic run_cycle(input string req, input int code, input int hold, input int wait_clks);
    bus_stat = 3'(code);
    step();
    check({req, " ale clock"}, 32'(outs()), 32'(expect_vec(code, 1)));
    step();
    check({req, " first command clock"}, 32'(outs()), 32'(expect_vec(code, 2)));
    for (int i = 0; i < hold; i++) begin
      step();
      check({req, " command held"}, 32'(outs()), 32'(expect_vec(code, 3)));
    end
    bus_stat = 3'd7;
    if (wait_clks > 0) begin
      rdy = 1'b0;
      for (int i = 0; i < wait_clks; i++) begin
        step();
        check({req, " R5 held while not ready"}, 32'(outs()), 32'(expect_vec(code, 3)));
      end
      rdy = 1'b1;
    end
    step();
    check({req, " released"}, 32'(outs()), 32'(expect_vec(code, 0)));
  endtask

  task automatic t_reset();
    check("R1 outputs", 32'(outs()), 32'(expect_vec(0, 0)));
    check("R1 seg_hot", 32'(seg_hot), 32'h1);
    check("R1 qs_hot", 32'(qs_hot), 32'h1);
  endtask

  task automatic t_reads();
    run_cycle("R2 R4 memory read", 5, 2, 0);
    run_cycle("R2 R4 code fetch", 4, 1, 0);
    run_cycle("R2 R4 R7 io read", 1, 3, 0);
    run_cycle("R2 R4 R7 interrupt ack", 0, 1, 0);
  endtask

  task automatic t_writes();
    run_cycle("R2 R6 R7 memory write", 6, 2, 0);
    run_cycle("R2 R6 R8 io write", 2, 1, 0);
  endtask

  task automatic t_ready();
    run_cycle("R5 io read wait", 1, 1, 3);
    run_cycle("R5 memory write wait", 6, 1, 2);
  endtask

  task automatic t_halt();
    run_cycle("R9 halt", 3, 2, 0);
  endtask

  task automatic t_no_restart();
    bus_stat = 3'd5;
    step();
    check("R3 start", 32'(ale), 32'd1);
    step();
    step();
    bus_stat = 3'd6;
    for (int i = 0; i < 2; i++) begin
      step();
      check("R10 no restart on code change", 32'(outs()), 32'(expect_vec(5, 3)));
    end
    bus_stat = 3'd7;
    step();
    check("R10 end after change", 32'(outs()), 32'(expect_vec(5, 0)));
    step();
    check("R3 idle while passive", 32'(outs()), 32'(expect_vec(0, 0)));
  endtask

  task automatic t_onehots();
    for (int c = 0; c < 4; c++) begin
      seg_code = 2'(c);
      qs_code  = 2'(3 - c);
      step();
      check("R11 seg_hot", 32'(seg_hot), 32'(4'b0001 << c));
      check("R12 qs_hot", 32'(qs_hot), 32'(4'b0001 << (3 - c)));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step();
    t_reset();
    t_reads();
    t_writes();
    t_ready();
    t_halt();
    t_no_restart();
    t_onehots();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule